// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a small register-programmed master for Clause 22 PHY management. Software first sets an enable bit in the control register. It then writes one 32-bit maintenance word that holds the whole frame: start indication, operation, PHY address, register address, turnaround pattern and sixteen data bits. The block sends 32 preamble ones and then the maintenance word itself, most significant bit first, on a divided management clock. While the frame is in progress it clears an idle flag in the status register.

For a read, the block stops driving the data line from the first turnaround bit onwards. It samples the sixteen returned bits on the rising management clock edges and, when the frame ends, places them in the low half of the maintenance word. The upper half keeps its value. Software polls the idle flag and then reads the maintenance word back. The management clock stays low between frames. A maintenance write that arrives while a frame is running is dropped.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Register word addresses: 0 is control, whose bit 4 is the management enable (read/write, other bits read 0); 1 is status, whose bit 2 reads 1 exactly when no frame is running; 2 is the maintenance word (read/write); 3 reads 0.
- R2: After reset the control and maintenance registers read 0, the idle bit reads 1, `mdc` is low and `mdio_oe` is low.
- R3: A maintenance write made while enabled and idle stores the word and starts a frame; the idle bit reads 0 from the next clock cycle on.
- R4: A frame is 64 bits: 32 ones, then maintenance bits 31 down to 0. In that word, bit 30 is the start indication, bits 29:28 are the operation (01 write, 10 read), 27:23 the PHY address, 22:18 the register address, 17:16 the turnaround 10, and 15:0 the data. `mdio_o` changes only after a falling `mdc` edge and is stable at each rising edge.
- R5: For a read (bits 29:28 = 10), `mdio_oe` is low from frame bit 46 (word bit 17) to the end of the frame. `mdio_i` is sampled at the rising `mdc` edges of frame bits 48..63, MSB first. When the frame ends, these bits replace maintenance bits 15:0 and bits 31:16 are unchanged.
- R6: For a write (bits 29:28 = 01), `mdio_oe` is high for all 64 frame bits, and the maintenance word keeps its value after the frame.
- R7: `mdc` has a period of 2*HALF_PERIOD clocks, starting with a low half, and is low whenever the block is idle. A frame keeps the idle bit at 0 for exactly 128*HALF_PERIOD clocks.
- R8: A maintenance write made while a frame is running is ignored: the stored word is unchanged and no further frame follows.
- R9: A maintenance write made while the enable is 0 stores the word but starts no frame: `mdc` stays low and the idle bit stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register word address for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven to the PHY |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| mdio_i | input | 1 | Management data returned by the PHY |

## Verification
The assertions assume that `reg_wr` is a single-cycle strobe and that software writes only well-formed maintenance words, with a valid operation code. The bench meets this by writing only through a task that drives the strobe for one cycle and by using vectors whose operation field is 01 or 10. The assertions also assume that `mdio_i` is driven from the falling clock side. The bench PHY model changes `mdio_i` only on falling system-clock edges, after it has seen a rising `mdc`. This keeps every sampled bit settled well ahead of the next rising `mdc`.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    localparam int WORD_W        = 32;
    localparam int DATA_W        = 16;
    localparam int PRE_LEN       = 32;
    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_STAT  = 2'd1;
    localparam logic [1:0] ADDR_MAINT = 2'd2;
    localparam int CTRL_EN_BIT   = 4;
    localparam int STAT_IDLE_BIT = 2;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_PERIOD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } gen_st_t;

    gen_st_t s_d, s_q;
    logic    wrap;

    always_comb begin
        s_d  = s_q;
        wrap = (s_q.cnt == LAST);
        if (!run) begin
            s_d.cnt = '0;
            s_d.mdc = 1'b0;
        end else if (wrap) begin
            s_d.cnt = '0;
            s_d.mdc = ~s_q.mdc;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc      = s_q.mdc;
    assign rise_stb = run && wrap && !s_q.mdc;
    assign fall_stb = run && wrap && s_q.mdc;
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine #(
    parameter int WORD_W      = mdio_mgmt_pkg::WORD_W,
    parameter int DATA_W      = mdio_mgmt_pkg::DATA_W,
    parameter int PRE_LEN     = mdio_mgmt_pkg::PRE_LEN,
    parameter int HALF_PERIOD = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rd_data
);
    localparam int NBITS     = PRE_LEN + WORD_W;
    localparam int IW        = $clog2(NBITS);
    localparam int TA_IDX    = PRE_LEN + WORD_W - DATA_W - 2;
    localparam int DATA_IDX  = TA_IDX + 2;
    localparam int OP_LSB    = WORD_W - 4;
    localparam int FRAME_CYC = NBITS * 2 * HALF_PERIOD;
    localparam int CCW       = $clog2(FRAME_CYC + 1) + 1;

    typedef struct packed {
        logic              busy;
        logic              is_rd;
        logic [IW-1:0]     idx;
        logic [WORD_W-1:0] frame;
        logic [DATA_W-1:0] rd_sh;
    } eng_st_t;

    eng_st_t s_d, s_q;
    logic    last_bit;
    logic    in_pre;

    always_comb begin
        s_d      = s_q;
        last_bit = (s_q.idx == IW'(NBITS - 1));
        in_pre   = (s_q.idx < IW'(PRE_LEN));
        done     = s_q.busy && fall_stb && last_bit;
        if (start && !s_q.busy) begin
            s_d.busy  = 1'b1;
            s_d.idx   = '0;
            s_d.frame = word;
            s_d.is_rd = (word[OP_LSB+1:OP_LSB] == mdio_mgmt_pkg::OP_READ);
            s_d.rd_sh = '0;
        end else if (s_q.busy) begin
            if (rise_stb && s_q.is_rd && s_q.idx >= IW'(DATA_IDX))
                s_d.rd_sh = {s_q.rd_sh[DATA_W-2:0], mdio_i};
            if (fall_stb) begin
                if (last_bit) begin
                    s_d.busy = 1'b0;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                    if (!in_pre) s_d.frame = {s_q.frame[WORD_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy    = s_q.busy;
    assign mdio_o  = s_q.busy && (in_pre || s_q.frame[WORD_W-1]);
    assign mdio_oe = s_q.busy && !(s_q.is_rd && s_q.idx >= IW'(TA_IDX));
    assign rd_data = s_q.rd_sh;

    logic [CCW-1:0] chk_cyc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         chk_cyc_q <= '0;
        else if (!s_q.busy) chk_cyc_q <= '0;
        else                chk_cyc_q <= chk_cyc_q + 1'b1;
    end

    assert_frame_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (chk_cyc_q < CCW'(FRAME_CYC)));

    assert_drive_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
    parameter int HALF_PERIOD = 4,
    parameter int WORD_W      = mdio_mgmt_pkg::WORD_W,
    parameter int DATA_W      = mdio_mgmt_pkg::DATA_W,
    parameter int PRE_LEN     = mdio_mgmt_pkg::PRE_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    import mdio_mgmt_pkg::*;

    localparam int OP_LSB = WORD_W - 4;

    typedef struct packed {
        logic [WORD_W-1:0] maint;
        logic              en;
    } top_st_t;

    top_st_t           s_d, s_q;
    logic              busy, done, start, wr_maint;
    logic              rise_stb, fall_stb;
    logic [DATA_W-1:0] rd_data;

    assign wr_maint = reg_wr && (reg_addr == ADDR_MAINT);
    assign start    = wr_maint && s_q.en && !busy;

    always_comb begin
        s_d = s_q;
        if (reg_wr && reg_addr == ADDR_CTRL) s_d.en = reg_wdata[CTRL_EN_BIT];
        if (wr_maint && !busy) s_d.maint = reg_wdata;
        if (done && s_q.maint[OP_LSB+1:OP_LSB] == OP_READ)
            s_d.maint[DATA_W-1:0] = rd_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL:  reg_rdata[CTRL_EN_BIT]   = s_q.en;
            ADDR_STAT:  reg_rdata[STAT_IDLE_BIT] = !busy;
            ADDR_MAINT: reg_rdata                = s_q.maint;
            default:    reg_rdata                = '0;
        endcase
    end

    mdio_mdc_gen #(.HALF_PERIOD(HALF_PERIOD)) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_engine #(
        .WORD_W      (WORD_W),
        .DATA_W      (DATA_W),
        .PRE_LEN     (PRE_LEN),
        .HALF_PERIOD (HALF_PERIOD)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .word     (reg_wdata),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (done),
        .rd_data  (rd_data)
    );

    assert_mdc_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    assert_oe_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_maint && s_q.en && !busy) |=> busy);

    assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_maint && busy && !done) |=> $stable(s_q.maint));

    assert_no_start_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.en && !busy) |=> !busy);
endmodule

// File: tb/sim_mdio_mgmt_ctrl.sv
module sim_mdio_mgmt_ctrl;
    localparam int HP        = 4;
    localparam int FRAME_CYC = 128 * HP;
    localparam int NVEC      = 4;
    localparam logic [31:0] VEC_W [NVEC] = '{32'h5082_1234, 32'h618A_0000,
                                             32'h5FFE_FFFF, 32'h6006_AAAA};
    localparam logic [15:0] VEC_R [NVEC] = '{16'h0000, 16'hBEEF,
                                             16'h0000, 16'h0001};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mdio_mgmt_ctrl #(.HALF_PERIOD(HP)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic run_frame(input logic [31:0] w, input logic [15:0] resp,
                             output logic [63:0] bits, output logic [63:0] oes,
                             output int nrise, output int ncyc);
        logic prev;
        logic [31:0] st;
        bits = '0; oes = '0; nrise = 0; ncyc = 0; prev = 1'b0; mdio_i = 1'b0;
        reg_write(2'd2, w);
        reg_read(2'd1, st);
        while (!st[2] && ncyc < 4 * FRAME_CYC) begin
            if (mdc && !prev) begin
                if (nrise < 64) begin
                    bits[63-nrise] = mdio_o;
                    oes[63-nrise]  = mdio_oe;
                end
                nrise++;
                mdio_i = (nrise >= 48 && nrise < 64) ? resp[63-nrise] : 1'b0;
            end
            prev = mdc;
            ncyc++;
            @(negedge clk);
            reg_read(2'd1, st);
        end
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [63:0] bits, oes, expf, expo;
        logic [31:0] fin;
        int nr, nc;
        bit moved;

        repeat (3) @(negedge clk);
        // R2: reset state
        reg_read(2'd1, d); chk(d == 32'h4, "R2 status after reset", d, 32'h4);
        reg_read(2'd0, d); chk(d == 0, "R2 control after reset", d, 0);
        reg_read(2'd2, d); chk(d == 0, "R2 maint after reset", d, 0);
        chk(!mdc && !mdio_oe, "R2 mdc/oe low", {mdc, mdio_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: write with enable clear stores the word but starts nothing
        reg_write(2'd2, 32'h5082_1234);
        moved = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            reg_read(2'd1, d);
            if (mdc || !d[2]) moved = 1;
        end
        chk(!moved, "R9 no frame while disabled", moved, 0);
        reg_read(2'd2, d); chk(d == 32'h5082_1234, "R9 word stored", d, 32'h5082_1234);

        // R1: register map
        reg_write(2'd0, 32'hFFFF_FFFF);
        reg_read(2'd0, d); chk(d == 32'h10, "R1 control readback", d, 32'h10);
        reg_read(2'd3, d); chk(d == 0, "R1 unused address", d, 0);

        // Table of frames: R3 R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            bit rd;
            rd   = (VEC_W[i][29:28] == 2'b10);
            expf = {32'hFFFF_FFFF, VEC_W[i]};
            expo = rd ? 64'hFFFF_FFFF_FFFC_0000 : 64'hFFFF_FFFF_FFFF_FFFF;
            fin  = rd ? {VEC_W[i][31:16], VEC_R[i]} : VEC_W[i];
            run_frame(VEC_W[i], VEC_R[i], bits, oes, nr, nc);
            chk(nc == FRAME_CYC, "R3 R7 busy duration", nc, FRAME_CYC);
            chk(nr == 64, "R7 mdc rising edges", nr, 64);
            if (rd) chk(bits[63:18] == expf[63:18], "R4 read frame header",
                        bits, expf);
            else    chk(bits == expf, "R4 write frame bits", bits, expf);
            chk(oes == expo, rd ? "R5 read release" : "R6 write drive", oes, expo);
            reg_read(2'd2, d);
            chk(d == fin, rd ? "R5 read data returned" : "R6 word kept", d, fin);
            chk(!mdc && !mdio_oe, "R7 mdc low after frame", {mdc, mdio_oe}, 0);
        end

        // R3: idle drops on the cycle after the write
        reg_write(2'd2, 32'h5082_0001);
        reg_read(2'd1, d); chk(d[2] == 1'b0, "R3 idle cleared", d, 0);
        // R7: first half-period of mdc is low
        repeat (HP - 1) @(negedge clk);
        chk(!mdc, "R7 first half low", mdc, 0);
        @(negedge clk);
        chk(mdc, "R7 rises after half period", mdc, 1);
        // R8: write while busy ignored
        repeat (40) @(negedge clk);
        reg_write(2'd2, 32'h6006_5555);
        reg_read(2'd2, d); chk(d == 32'h5082_0001, "R8 busy write dropped", d, 32'h5082_0001);
        nc = 0;
        reg_read(2'd1, d);
        while (!d[2] && nc < 2 * FRAME_CYC) begin
            @(negedge clk); nc++; reg_read(2'd1, d);
        end
        moved = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            reg_read(2'd1, d);
            if (mdc || !d[2]) moved = 1;
        end
        chk(!moved, "R8 no follow-on frame", moved, 0);
        reg_read(2'd2, d); chk(d == 32'h5082_0001, "R8 word after frame", d, 32'h5082_0001);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule